// File: doc/BRIEF.md
# ECC Page Report Tally

This block sits after a hardware BCH page decoder and turns the decoder's one-word error report into a per-page verdict. The verdict is either the worst bitflip count seen in any packet of the page or an uncorrectable flag. The report word carries two counts: one for the leading packet of the page, and one that is already the largest count over every later packet. Each count has a success bit that reads zero when its decode failed. A separate blank-page flag tells the block that the page was never programmed. In that case the report word means nothing and the page reads as clean.

The block also keeps two running totals. One adds up the corrected bits and the other counts the pages that could not be corrected. Both totals stop at all ones and never wrap. A synchronous clear input resets them. Either total can be read through a one-bit select and a data bus. An uncorrectable page also raises a one-cycle request, so that software can check whether the page is really an erased page with a few flipped bits.

Top module: `ecc_report_tally`

## Requirements
- R1: A report strobe sampled at a rising edge produces a single-cycle `res_valid` pulse in the cycle after that edge. Without a strobe, `res_valid` stays low.
- R2: The leading-packet count is taken from word bits [5:0], and the later-packets maximum from bits [13:8]. On a clean page `res_flips` equals the larger of the two.
- R3: Bit 7 is the leading-packet decode success and bit 15 is the later-packets decode success; both are active high. If either bit is zero, the page is uncorrectable: `res_fail` is 1 and `res_flips` is 0.
- R4: When `page_blank` is high, the report word is ignored. The result is `res_fail`=0 and `res_flips`=0, and neither total changes.
- R5: On a clean page, the corrected-bits total grows by the sum of the two counts.
- R6: On an uncorrectable page, the failed-page total grows by one and the corrected-bits total is left unchanged.
- R7: `erase_chk_req` is high for exactly the result cycle of each uncorrectable page and is low at all other times.
- R8: Both totals saturate at all ones and hold that value under further increments.
- R9: `clr` sets both totals to zero at the next edge. It takes priority over an increment in the same cycle, and the result outputs still appear for that cycle's report.
- R10: Reset drives both totals, `res_valid`, `res_fail`, `res_flips` and `erase_chk_req` to zero.
- R11: `rd_data` shows the corrected-bits total when `rd_sel`=0 and the failed-page total when `rd_sel`=1, with no added register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both totals |
| rpt_valid | input | 1 | Report word and blank flag are valid this cycle |
| rpt_word | input | WORD_W | Decoder error report |
| page_blank | input | 1 | Page was read as never programmed |
| res_valid | output | 1 | Page result is present |
| res_fail | output | 1 | Page is uncorrectable |
| res_flips | output | CNT_W | Worst packet bitflip count |
| erase_chk_req | output | 1 | Request for a software erased-page check |
| rd_sel | input | 1 | Readback select: 0 corrected bits, 1 failed pages |
| rd_data | output | ACC_W | Selected total |

## Verification
The assertions assume that `rpt_word` and `page_blank` are meaningful only while `rpt_valid` is high. They also assume that `clr` and `rpt_valid` are plain synchronous levels that change away from the clock edge. The bench drives every input at the falling edge and holds each strobe for exactly one cycle. It leaves the report word at arbitrary values between strobes. The saturation checks in the accumulators rely on the increment never exceeding the total's own width. The bench therefore builds the block with 8-bit totals: the largest corrected-bits step of 126 then fits, and saturation is reached in a few hundred cycles.

// File: rtl/ecc_tally_pkg.sv
package ecc_tally_pkg;

   typedef enum logic [1:0] {
      PG_CLEAN = 2'd0,
      PG_BLANK = 2'd1,
      PG_FAIL  = 2'd2
   } pg_class_e;

endpackage

// File: rtl/ecc_report_decode.sv
module ecc_report_decode
   import ecc_tally_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 6,
   parameter int P0_LSB = 0,
   parameter int PN_LSB = 8,
   parameter int P0_OK  = 7,
   parameter int PN_OK  = 15
) (
   input  logic [WORD_W-1:0] word,
   input  logic              blank,
   output pg_class_e         cls,
   output logic [CNT_W-1:0]  max_cnt,
   output logic [CNT_W:0]    sum_cnt
);

   if (P0_LSB + CNT_W > WORD_W || PN_LSB + CNT_W > WORD_W) begin : g_bad_fields
      $error("count field lies outside the report word");
   end
   if (P0_OK >= WORD_W || PN_OK >= WORD_W) begin : g_bad_okbits
      $error("success bit lies outside the report word");
   end

   logic [CNT_W-1:0] cnt_lead;
   logic [CNT_W-1:0] cnt_rest;
   logic             ok_lead;
   logic             ok_rest;

   assign cnt_lead = word[P0_LSB +: CNT_W];
   assign cnt_rest = word[PN_LSB +: CNT_W];
   assign ok_lead  = word[P0_OK];
   assign ok_rest  = word[PN_OK];

   always_comb begin
      if (blank)
         cls = PG_BLANK;
      else if (!ok_lead || !ok_rest)
         cls = PG_FAIL;
      else
         cls = PG_CLEAN;
      max_cnt = (cnt_lead > cnt_rest) ? cnt_lead : cnt_rest;
      sum_cnt = {1'b0, cnt_lead} + {1'b0, cnt_rest};
   end

endmodule

// File: rtl/ecc_sat_accum.sv
module ecc_sat_accum #(
   parameter int W        = 32,
   parameter int INC_W    = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     acc
);

   if (INC_W > W) begin : g_bad_inc
      $error("increment wider than accumulator");
   end

   localparam int PAD_W = W + 1 - INC_W;

   logic [W:0]   raw_sum;
   logic [W-1:0] next_val;

   assign raw_sum = {1'b0, acc} + {{PAD_W{1'b0}}, inc};

   if (SATURATE) begin : g_sat
      assign next_val = raw_sum[W] ? {W{1'b1}} : raw_sum[W-1:0];
   end else begin : g_wrap
      assign next_val = raw_sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (en)
         acc <= next_val;
   end

   a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(acc));

   if (SATURATE) begin : g_sat_chk
      a_r8_never_wraps: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && en) |=> (acc >= $past(acc)));
      a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && acc == {W{1'b1}}) |=> (acc == {W{1'b1}}));
   end

endmodule

// File: rtl/ecc_report_tally.sv
module ecc_report_tally
   import ecc_tally_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 6,
   parameter int ACC_W  = 32,
   parameter int P0_LSB = 0,
   parameter int PN_LSB = 8,
   parameter int P0_OK  = 7,
   parameter int PN_OK  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rpt_valid,
   input  logic [WORD_W-1:0] rpt_word,
   input  logic              page_blank,
   output logic              res_valid,
   output logic              res_fail,
   output logic [CNT_W-1:0]  res_flips,
   output logic              erase_chk_req,
   input  logic              rd_sel,
   output logic [ACC_W-1:0]  rd_data
);

   localparam int SUM_W = CNT_W + 1;

   pg_class_e        cls;
   logic [CNT_W-1:0] max_cnt;
   logic [SUM_W-1:0] sum_cnt;
   logic [ACC_W-1:0] corr_total;
   logic [ACC_W-1:0] fail_total;
   logic             take_clean;
   logic             take_fail;

   ecc_report_decode #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W),
      .P0_LSB (P0_LSB),
      .PN_LSB (PN_LSB),
      .P0_OK  (P0_OK),
      .PN_OK  (PN_OK)
   ) i_decode (
      .word    (rpt_word),
      .blank   (page_blank),
      .cls     (cls),
      .max_cnt (max_cnt),
      .sum_cnt (sum_cnt)
   );

   assign take_clean = rpt_valid && (cls == PG_CLEAN);
   assign take_fail  = rpt_valid && (cls == PG_FAIL);

   ecc_sat_accum #(
      .W        (ACC_W),
      .INC_W    (SUM_W),
      .SATURATE (1'b1)
   ) i_corr_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (take_clean),
      .inc   (sum_cnt),
      .acc   (corr_total)
   );

   ecc_sat_accum #(
      .W        (ACC_W),
      .INC_W    (1),
      .SATURATE (1'b1)
   ) i_fail_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (take_fail),
      .inc   (1'b1),
      .acc   (fail_total)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_fail      <= 1'b0;
         res_flips     <= '0;
         erase_chk_req <= 1'b0;
      end else begin
         res_valid     <= rpt_valid;
         erase_chk_req <= take_fail;
         if (rpt_valid) begin
            res_fail  <= (cls == PG_FAIL);
            res_flips <= (cls == PG_CLEAN) ? max_cnt : '0;
         end
      end
   end

   assign rd_data = rd_sel ? fail_total : corr_total;

   a_r1_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> res_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rpt_valid |=> !res_valid);

   a_r4_blank_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && page_blank) |=> (!res_fail && res_flips == '0 && !erase_chk_req));

   a_r7_req_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !page_blank && !(rpt_word[P0_OK] && rpt_word[PN_OK])) |=> erase_chk_req);

   a_r7_req_only_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      erase_chk_req |-> (res_valid && res_fail));

   a_r6_corr_frozen_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid && !page_blank && !rpt_word[P0_OK] && !clr) |=> $stable(corr_total));

endmodule

// File: tb/test_ecc_report_tally.sv
module test_ecc_report_tally;

   localparam int ACC_W = 8;
   localparam int MAXV  = (1 << ACC_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             rpt_valid = 1'b0;
   logic [31:0]      rpt_word = '0;
   logic             page_blank = 1'b0;
   logic             res_valid;
   logic             res_fail;
   logic [5:0]       res_flips;
   logic             erase_chk_req;
   logic             rd_sel = 1'b0;
   logic [ACC_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int exp_corr = 0;
   int exp_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ecc_report_tally #(.ACC_W(ACC_W)) i_ecc_report_tally (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr           (clr),
      .rpt_valid     (rpt_valid),
      .rpt_word      (rpt_word),
      .page_blank    (page_blank),
      .res_valid     (res_valid),
      .res_fail      (res_fail),
      .res_flips     (res_flips),
      .erase_chk_req (erase_chk_req),
      .rd_sel        (rd_sel),
      .rd_data       (rd_data)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_totals(input string req);
      rd_sel = 1'b0;
      #1;
      chk({req, " corrected total"}, rd_data, exp_corr);
      rd_sel = 1'b1;
      #1;
      chk({req, " failed total"}, rd_data, exp_fail);
      rd_sel = 1'b0;
   endtask

   function automatic int sat_add(input int a, input int b);
      return (a + b > MAXV) ? MAXV : a + b;
   endfunction

   // one report; checks result in the following cycle, then that the pulse ends
   task automatic send(input logic [31:0] w, input logic blank, input logic with_clr,
                       input string req, input bit quiet);
      int  c0, cn, mx;
      bit  fail;
      c0   = int'(w[5:0]);
      cn   = int'(w[13:8]);
      mx   = (c0 > cn) ? c0 : cn;
      fail = !blank && (!w[7] || !w[15]);
      @(negedge clk);
      rpt_word   = w;
      page_blank = blank;
      rpt_valid  = 1'b1;
      clr        = with_clr;
      @(negedge clk);
      rpt_valid  = 1'b0;
      clr        = 1'b0;
      rpt_word   = 32'h0000_3f3f;
      page_blank = 1'b0;
      if (with_clr) begin
         exp_corr = 0;
         exp_fail = 0;
      end else if (fail) begin
         exp_fail = sat_add(exp_fail, 1);
      end else if (!blank) begin
         exp_corr = sat_add(exp_corr, c0 + cn);
      end
      if (!quiet) begin
         chk({req, " res_valid"}, res_valid, 1);
         chk({req, " res_fail"}, res_fail, fail);
         chk({req, " res_flips"}, res_flips, (fail || blank) ? 0 : mx);
         chk({req, " erase_chk_req"}, erase_chk_req, fail);
         check_totals(req);
         @(negedge clk);
         chk({req, " R1 pulse ends"}, res_valid, 0);
         chk({req, " R7 request ends"}, erase_chk_req, 0);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 res_valid", res_valid, 0);
      chk("R10 res_fail", res_fail, 0);
      chk("R10 res_flips", res_flips, 0);
      chk("R10 erase_chk_req", erase_chk_req, 0);
      exp_corr = 0;
      exp_fail = 0;
      check_totals("R10");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle no result", res_valid, 0);
   endtask

   task automatic t_clean_pages;
      send(32'h0000_8583, 1'b0, 1'b0, "R2 R5 rest larger", 1'b0);
      send(32'h0000_8289, 1'b0, 1'b0, "R2 R5 lead larger", 1'b0);
      send(32'h0000_8484, 1'b0, 1'b0, "R2 equal counts", 1'b0);
      send(32'hffff_8080, 1'b0, 1'b0, "R2 zero counts high bits set", 1'b0);
   endtask

   task automatic t_fail_pages;
      send(32'h0000_8505, 1'b0, 1'b0, "R3 R6 R7 lead fails", 1'b0);
      send(32'h0000_0a8a, 1'b0, 1'b0, "R3 R6 R7 rest fails", 1'b0);
      send(32'h0000_0101, 1'b0, 1'b0, "R3 R6 both fail", 1'b0);
   endtask

   task automatic t_blank;
      send(32'h0000_3f3f, 1'b1, 1'b0, "R4 blank with fail bits", 1'b0);
      send(32'h0000_bfbf, 1'b1, 1'b0, "R4 blank with counts", 1'b0);
   endtask

   task automatic t_clear;
      send(32'h0000_8202, 1'b0, 1'b1, "R9 clear beats update", 1'b0);
      send(32'h0000_0303, 1'b0, 1'b0, "R9 fail after clear", 1'b0);
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      exp_corr = 0;
      exp_fail = 0;
      check_totals("R9 lone clear");
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 4; i++)
         send(32'h0000_bfbf, 1'b0, 1'b0, "R8", 1'b1);
      check_totals("R8 corrected saturates");
      send(32'h0000_8181, 1'b0, 1'b0, "R8 hold at max", 1'b0);
      for (int i = 0; i < MAXV + 3; i++)
         send(32'h0000_0000, 1'b0, 1'b0, "R8", 1'b1);
      check_totals("R8 failed saturates");
      rd_sel = 1'b1;
      #1;
      chk("R11 select failed", rd_data, MAXV);
      rd_sel = 1'b0;
      #1;
      chk("R11 select corrected", rd_data, MAXV);
   endtask

   initial begin
      t_reset();
      t_clean_pages();
      t_fail_pages();
      t_blank();
      t_clear();
      t_saturate();
      t_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule